// File: doc/BRIEF.md
# Loop-Progress Save and Replay Unit

This unit sits next to the functional unit (FU) of one tile in a reconfigurable array. When the array is switched out of its current kernel, it records how far a loop got. When the kernel is switched back in, it hands that loop position back to the FU. A loop keeps its iteration index in one particular PHI_CONST operation. That operation is identified by the control-memory slot that holds it, and software loads this slot number into the unit with a dedicated command before the switch.

After a halt command the unit is in the pausing phase. The first time the FU runs PHI_CONST from the loaded slot, the unit copies the FU result word into its progress register. In that same cycle it raises a flag that makes the FU mark its own output as invalid. After a continue command the unit is in the resuming phase. The first time that same operation runs, the unit drives the saved word on its progress output with the predicate set. The FU uses it in place of a freshly computed index. Each phase acts once, and it acts again only after the next command of the same kind.

Top module: `ctx_progress_keeper`

## Requirements
- R1: After reset the phase is idle, the saved progress word is zero and the loaded slot is zero. All outputs are zero until a phase command arrives.
- R2: The slot-load command (code 1) copies `anchor_addr_i` into the slot register at the clock edge that ends the command cycle.
- R3: The halt command (code 2) puts the unit in the pausing phase, and the continue command (code 3) puts it in the resuming phase. In both cases the new phase applies from the next cycle.
- R4: In the pausing phase, a cycle is a capture cycle when `op_i` equals PHI_CONST (code 5) and `ctrl_rd_addr_i` equals the loaded slot. In the first such cycle, `force_pred_o` is 1 and `fu_data_i` is written to the progress register at the closing edge.
- R5: Nothing else changes the progress register. This covers PHI_CONST at any other slot, any other operation at the loaded slot, and any FU result outside the pausing phase.
- R6: After one capture, `force_pred_o` stays 0 and the progress register holds its value until a new halt command re-arms capture. `force_pred_o` is 0 in every cycle that is not a capture cycle.
- R7: In the resuming phase, in the first cycle where the capture condition's operation and slot match hold, `prog_data_o` shows the saved word and `prog_pred_o` is 1. In every other cycle both are 0.
- R8: After one replay, no further replay happens until a new continue command re-arms it.
- R9: Command codes other than 1, 2 and 3 leave the phase, the slot register and the one-shot state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | CMD_W (4) | Command code for this cycle; 0 means no command |
| op_i | input | OP_W (6) | Operation the FU runs this cycle |
| ctrl_rd_addr_i | input | ADDR_W | Control-memory slot the FU runs from |
| anchor_addr_i | input | ADDR_W | Slot number taken by the slot-load command |
| fu_data_i | input | DATA_W | FU result word |
| prog_data_o | output | DATA_W | Replayed progress word, zero when not replaying |
| prog_pred_o | output | 1 | 1 in the replay cycle only |
| force_pred_o | output | 1 | 1 in the capture cycle only; clears the FU output predicate |

## Verification
The bench feeds a PHI_CONST from a neighbouring slot, carrying a plausible valid word, just before the real one. A unit that matched on the operation alone would save the wrong word, and the later replay would show it. Repeated hits inside one phase test the one-shot behaviour: a unit missing it would overwrite the saved word during pausing, or replay twice during resuming. Re-issued halt and continue commands check re-arming, and unknown command codes sent in the middle of a phase check that a loose decoder does not drop the phase. A long stretch of mixed random traffic is compared against a behavioural model on every cycle.

// File: rtl/ctx_progress_pkg.sv
package ctx_progress_pkg;
  localparam int NUM_CMDS = 16;
  localparam int CMD_W    = $clog2(NUM_CMDS);
  localparam int NUM_OPS  = 64;
  localparam int OP_W     = $clog2(NUM_OPS);

  localparam logic [CMD_W-1:0] CMD_LOAD_SLOT = CMD_W'(1);
  localparam logic [CMD_W-1:0] CMD_HALT      = CMD_W'(2);
  localparam logic [CMD_W-1:0] CMD_CONTINUE  = CMD_W'(3);

  localparam logic [OP_W-1:0]  OP_PHI_CONST  = OP_W'(5);

  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_PAUSING  = 2'd1,
    PH_RESUMING = 2'd2
  } phase_e;
endpackage

// File: rtl/ctx_phase_ctrl.sv
module ctx_phase_ctrl
  import ctx_progress_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             capture_fire,
  input  logic             replay_fire,
  output phase_e           phase_q,
  output logic             cap_spent_q,
  output logic             rep_spent_q
);
  phase_e phase_d;
  logic   cap_spent_d, rep_spent_d;

  // A phase command re-arms its own one-shot. Re-arming wins over a hit in the same cycle.
  always_comb begin
    phase_d     = phase_q;
    cap_spent_d = cap_spent_q | capture_fire;
    rep_spent_d = rep_spent_q | replay_fire;
    unique case (cmd_i)
      CMD_HALT: begin
        phase_d     = PH_PAUSING;
        cap_spent_d = 1'b0;
      end
      CMD_CONTINUE: begin
        phase_d     = PH_RESUMING;
        rep_spent_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      cap_spent_q <= 1'b0;
      rep_spent_q <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      cap_spent_q <= cap_spent_d;
      rep_spent_q <= rep_spent_d;
    end
  end
endmodule

// File: rtl/ctx_slot_match.sv
module ctx_slot_match
  import ctx_progress_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [ADDR_W-1:0] anchor_addr_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] ctrl_rd_addr_i,
  output logic [ADDR_W-1:0] slot_q,
  output logic              slot_hit
);
  function automatic logic is_anchor_phi(input logic [OP_W-1:0] op,
                                         input logic [ADDR_W-1:0] addr,
                                         input logic [ADDR_W-1:0] slot);
    return (op == OP_PHI_CONST) && (addr == slot);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                     slot_q <= '0;
    else if (cmd_i == CMD_LOAD_SLOT) slot_q <= anchor_addr_i;
  end

  assign slot_hit = is_anchor_phi(op_i, ctrl_rd_addr_i, slot_q);
endmodule

// File: rtl/ctx_progress_store.sv
module ctx_progress_store #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_fire,
  input  logic              replay_fire,
  input  logic [DATA_W-1:0] fu_data_i,
  output logic [DATA_W-1:0] saved_q,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              prog_pred_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)            saved_q <= '0;
    else if (capture_fire) saved_q <= fu_data_i;
  end

  assign prog_data_o = replay_fire ? saved_q : '0;
  assign prog_pred_o = replay_fire;
endmodule

// File: rtl/ctx_progress_keeper.sv
module ctx_progress_keeper
  import ctx_progress_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] ctrl_rd_addr_i,
  input  logic [ADDR_W-1:0] anchor_addr_i,
  input  logic [DATA_W-1:0] fu_data_i,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              prog_pred_o,
  output logic              force_pred_o
);
  phase_e            phase_q;
  logic              cap_spent_q, rep_spent_q;
  logic [ADDR_W-1:0] slot_q;
  logic              slot_hit;
  logic [DATA_W-1:0] saved_q;
  logic              in_pause, in_resume;
  logic              capture_fire, replay_fire;

  assign in_pause     = (phase_q == PH_PAUSING);
  assign in_resume    = (phase_q == PH_RESUMING);
  assign capture_fire = in_pause  & slot_hit & ~cap_spent_q;
  assign replay_fire  = in_resume & slot_hit & ~rep_spent_q;
  assign force_pred_o = capture_fire;

  ctx_phase_ctrl u_phase (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i),
    .capture_fire(capture_fire), .replay_fire(replay_fire),
    .phase_q(phase_q), .cap_spent_q(cap_spent_q), .rep_spent_q(rep_spent_q)
  );

  ctx_slot_match #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .anchor_addr_i(anchor_addr_i),
    .op_i(op_i), .ctrl_rd_addr_i(ctrl_rd_addr_i),
    .slot_q(slot_q), .slot_hit(slot_hit)
  );

  ctx_progress_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .capture_fire(capture_fire), .replay_fire(replay_fire),
    .fu_data_i(fu_data_i), .saved_q(saved_q),
    .prog_data_o(prog_data_o), .prog_pred_o(prog_pred_o)
  );
endmodule

// File: rtl/ctx_progress_checker.sv
module ctx_progress_checker
  import ctx_progress_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CMD_W-1:0]  cmd_i,
  input logic [DATA_W-1:0] fu_data_i,
  input logic [DATA_W-1:0] saved_q,
  input logic [DATA_W-1:0] prog_data_o,
  input logic              prog_pred_o,
  input logic              force_pred_o,
  input logic              in_pause,
  input logic              in_resume
);
  assert_halt_enters_pause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_HALT) |=> in_pause);
  assert_continue_enters_resume_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_CONTINUE) |=> in_resume);
  assert_force_only_pausing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_pred_o |-> in_pause);
  assert_capture_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_pred_o |=> (saved_q == $past(fu_data_i)));
  assert_store_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !force_pred_o |=> $stable(saved_q));
  assert_capture_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_pred_o && cmd_i != CMD_HALT) |=> !force_pred_o);
  assert_replay_only_resuming_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pred_o |-> in_resume);
  assert_quiet_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_pred_o |-> (prog_data_o == '0));
  assert_replay_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_pred_o && cmd_i != CMD_CONTINUE) |=> !prog_pred_o);
endmodule

bind ctx_progress_keeper ctx_progress_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .fu_data_i(fu_data_i), .saved_q(saved_q),
  .prog_data_o(prog_data_o), .prog_pred_o(prog_pred_o), .force_pred_o(force_pred_o),
  .in_pause(in_pause), .in_resume(in_resume)
);

// File: tb/ctx_progress_keeper_bench.sv
module ctx_progress_keeper_bench;
  localparam int DW = 16;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    cmd_i = '0;
  logic [5:0]    op_i = '0;
  logic [AW-1:0] ctrl_rd_addr_i = '0;
  logic [AW-1:0] anchor_addr_i = '0;
  logic [DW-1:0] fu_data_i = '0;
  logic [DW-1:0] prog_data_o;
  logic          prog_pred_o, force_pred_o;

  int n_checks = 0;
  int n_fail = 0;

  // Reference state: 0 idle, 1 pausing, 2 resuming
  int m_phase = 0;
  int m_slot = 0;
  int m_saved = 0;
  bit m_cap_used = 0;
  bit m_rep_used = 0;

  always #5ns clk = ~clk;

  ctx_progress_keeper #(.DATA_W(DW), .ADDR_W(AW)) u_ctx_progress_keeper (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .op_i(op_i),
    .ctrl_rd_addr_i(ctrl_rd_addr_i), .anchor_addr_i(anchor_addr_i),
    .fu_data_i(fu_data_i), .prog_data_o(prog_data_o),
    .prog_pred_o(prog_pred_o), .force_pred_o(force_pred_o)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, compare the outputs, then step the model at the rising edge.
  task automatic step(input int cmd, input int op, input int addr, input int anc, input int data);
    bit hit, cap, rep;
    @(negedge clk);
    cmd_i = 4'(cmd); op_i = 6'(op); ctrl_rd_addr_i = AW'(addr);
    anchor_addr_i = AW'(anc); fu_data_i = DW'(data);
    #2ns;
    hit = (op == 5) && (addr == m_slot);
    cap = (m_phase == 1) && hit && !m_cap_used;
    rep = (m_phase == 2) && hit && !m_rep_used;
    check(cap ? "R4 capture flag" : "R6 flag quiet", int'(force_pred_o), int'(cap));
    check(rep ? "R7 replay pred" : "R8 pred quiet", int'(prog_pred_o), int'(rep));
    check(rep ? "R7 replay word" : "R5 word quiet", int'(prog_data_o), rep ? m_saved : 0);
    @(posedge clk);
    if (cap) begin m_saved = data; m_cap_used = 1; end
    if (rep) m_rep_used = 1;
    case (cmd)
      1: m_slot = anc;
      2: begin m_phase = 1; m_cap_used = 0; end
      3: begin m_phase = 2; m_rep_used = 0; end
      default: ; // R9: other codes ignored
    endcase
  endtask

  initial begin
    #2_000_000ns;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state, outputs quiet, slot zero
    check("R1 flag", int'(force_pred_o), 0);
    check("R1 pred", int'(prog_pred_o), 0);
    step(0, 5, 0, 0, 11);       // R1 idle: PHI at slot 0 captures nothing
    step(2, 0, 0, 0, 0);        // R3 halt
    step(0, 5, 0, 0, 16'h0AAA); // R1 slot zero after reset -> capture
    step(3, 0, 0, 0, 0);        // R3 continue
    step(0, 5, 0, 0, 0);        // R7 replay 0x0AAA
    // R2 load slot 3, then a paused phase
    step(1, 0, 0, 3, 0);
    step(2, 0, 0, 0, 0);
    step(0, 5, 0, 0, 4321);     // R5 old slot no longer matches
    step(0, 5, 2, 0, 8765);     // R5 neighbouring PHI_CONST
    step(0, 9, 3, 0, 2222);     // R5 other op at slot
    step(7, 0, 0, 0, 0);        // R9 unknown command keeps pausing
    step(0, 5, 3, 0, 1234);     // R4 capture
    step(0, 5, 3, 0, 9999);     // R6 no second capture
    step(3, 0, 0, 0, 0);
    step(0, 5, 2, 0, 0);        // R7 no replay at other slot
    step(12, 0, 0, 0, 0);       // R9 ignored inside resuming
    step(0, 5, 3, 0, 7777);     // R7 replay 1234; R5 not captured
    step(0, 5, 3, 0, 0);        // R8 no second replay
    step(3, 0, 0, 0, 0);        // R8 re-arm
    step(0, 5, 3, 0, 0);        // R8 replay again
    step(2, 0, 0, 0, 0);        // R6 re-arm capture
    step(0, 5, 3, 0, 5555);
    step(3, 5, 3, 0, 0);        // R8 replay blocked by pausing, continue same cycle
    step(0, 5, 3, 0, 0);        // R7 replay 5555
    // Mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 19);
      int c = (r < 3) ? r + 1 : ((r == 3) ? 9 : 0);
      step(c, ($urandom_range(0, 2) == 0) ? 4 : 5, $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom_range(0, 65535));
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule